// File: doc/BRIEF.md
# Clock-Forwarding Bidirectional Bus Transceiver Controller

This block models the control and data path of a wide bidirectional bus transceiver that sends a clock along with its data. Two data sides, A and B, each have an input value, an output value and an active-high drive enable that stands for a tri-state pin. A direction input picks which side is the source. A clock-release input does two jobs. When it is low, data reaches the destination through a per-direction capture register and the clock outputs are driven. When it is high, data passes straight through and both clock outputs are released. A separate data-release input lets go of both data sides, while the registers and the clock paths keep running.

The clock inputs (the system clock level and the forwarded B-side clock level) are sampled by the core clock `clk`. The rising edges found that way are the capture events. In the B-to-A direction a mode input chooses the capture event. It is either the forwarded clock that arrives with the data (source-synchronous) or the local system clock, in which case the block itself drives the forwarded clock (clock-synchronous). Reset is synchronous and active low, and it clears both capture registers to zero.

Top module: `clkfwd_xcvr`

## Requirements
- R1: `dir_btoa`=0 sends data from A to B and `dir_btoa`=1 sends it from B to A, with no inversion. `a_drive` and `b_drive` are never high together.
- R2: With `data_off`=1 and `clk_off`=0, `a_drive` and `b_drive` are both 0, and `lclk_drive` stays 1.
- R3: With `clk_off`=0, `data_off`=0 and `dir_btoa`=0, `b_out` shows the A-to-B register. That register takes `a_in` at the first `clk` edge that samples `sys_clk_i` high after it was sampled low.
- R4: Without a capture edge, the selected register holds its value however the source data changes.
- R5: With `clk_off`=1 and `data_off`=0, the destination output equals the source input in the same cycle, and `fclk_drive` and `lclk_drive` are 0.
- R6: In A-to-B with `clk_off`=0, `fclk_drive`=1, `fclk_out` follows `sys_clk_i`, and `lclk_out` follows `sys_clk_i` with `lclk_drive`=1, whatever the value of `data_off`.
- R7: In B-to-A with `clk_off`=0 and `cap_local`=0, `fclk_drive`=0, `lclk_out` follows `fclk_in`, and the B-to-A register captures `b_in` only on rising `fclk_in` edges, never on `sys_clk_i` edges.
- R8: In B-to-A with `clk_off`=0 and `cap_local`=1, `fclk_drive`=1 with `fclk_out` following `sys_clk_i`, `lclk_out` follows `sys_clk_i`, and capture happens only on rising `sys_clk_i` edges.
- R9: With `data_off`=1 and `clk_off`=0, both registers load on their capture edges (A-to-B from `a_in` on the system clock, B-to-A from `b_in` on the edge that `cap_local` selects).
- R10: With `data_off`=1 and `clk_off`=1, all four drive enables are 0.
- R11: Outside of R9, a register whose direction is not selected does not load. Its value is therefore kept across direction changes.
- R12: After reset both registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples everything |
| rst_n | input | 1 | Synchronous active-low reset |
| sys_clk_i | input | 1 | System clock level |
| data_off | input | 1 | 1 releases both data sides |
| clk_off | input | 1 | 1 releases clocks and selects the transparent path |
| dir_btoa | input | 1 | 0 = A to B, 1 = B to A |
| cap_local | input | 1 | B-to-A capture: 0 = forwarded clock, 1 = system clock |
| a_in | input | WIDTH | A-side pin value as received |
| a_out | output | WIDTH | A-side value to drive |
| a_drive | output | 1 | A-side drive enable |
| b_in | input | WIDTH | B-side pin value as received |
| b_out | output | WIDTH | B-side value to drive |
| b_drive | output | 1 | B-side drive enable |
| fclk_in | input | 1 | Forwarded B-side clock as received |
| fclk_out | output | 1 | Forwarded clock value to drive |
| fclk_drive | output | 1 | Forwarded clock drive enable |
| lclk_out | output | 1 | Local clock output value |
| lclk_drive | output | 1 | Local clock output enable |

## Verification
The bench builds the block with its default width of 18 bits. Patterns with all ones, alternating bits and single top-bit values therefore reach both edges of the data path. A width that small also lets every control combination be swept against a truth table built from the requirements. Separate pulses on `sys_clk_i` and `fclk_in` show which clock each mode actually captures on and which one it ignores.

// File: rtl/clkfwd_xcvr_pkg.sv
package clkfwd_xcvr_pkg;

  // Lane indices of the sampled clock inputs
  localparam int CLK_SYS = 0;
  localparam int CLK_FWD = 1;
  localparam int NUM_CLK = 2;

  // Decoded routing for one control setting
  typedef struct packed {
    logic a_drv;
    logic b_drv;
    logic use_reg;
    logic fclk_drv;
    logic lclk_drv;
    logic lclk_fwd;
    logic ld_ab;
    logic ld_ba;
    logic ba_on_sys;
  } route_t;

endpackage

// File: rtl/clkfwd_xcvr_decode.sv
module clkfwd_xcvr_decode
  import clkfwd_xcvr_pkg::*;
(
  input  logic   data_off,
  input  logic   clk_off,
  input  logic   dir_btoa,
  input  logic   cap_local,
  output route_t route
);

  always_comb begin
    route           = '0;
    route.a_drv     = !data_off && dir_btoa;
    route.b_drv     = !data_off && !dir_btoa;
    route.use_reg   = !clk_off;
    route.lclk_drv  = !clk_off;
    // forwarded clock is an input only in source-synchronous receive
    route.fclk_drv  = !clk_off && (!dir_btoa || cap_local);
    route.lclk_fwd  = dir_btoa && !cap_local;
    // isolation lets both registers load
    route.ld_ab     = !clk_off && (!dir_btoa || data_off);
    route.ld_ba     = !clk_off && (dir_btoa || data_off);
    route.ba_on_sys = cap_local;
  end

endmodule

// File: rtl/clkfwd_xcvr_edge.sv
module clkfwd_xcvr_edge #(
  parameter int NUM = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] lvl,
  output logic [NUM-1:0] rise
);

  for (genvar i = 0; i < NUM; i++) begin : g_lane
    logic prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl[i];
    end
    assign rise[i] = lvl[i] && !prev_q;
  end

endmodule

// File: rtl/clkfwd_xcvr_capture.sv
module clkfwd_xcvr_capture #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/clkfwd_xcvr.sv
module clkfwd_xcvr
  import clkfwd_xcvr_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_clk_i,
  input  logic             data_off,
  input  logic             clk_off,
  input  logic             dir_btoa,
  input  logic             cap_local,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drive,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drive,
  input  logic             fclk_in,
  output logic             fclk_out,
  output logic             fclk_drive,
  output logic             lclk_out,
  output logic             lclk_drive
);

  route_t             route;
  logic [NUM_CLK-1:0] clk_lvl;
  logic [NUM_CLK-1:0] clk_rise;
  logic               ab_load;
  logic               ba_load;
  logic [WIDTH-1:0]   ab_q;
  logic [WIDTH-1:0]   ba_q;

  clkfwd_xcvr_decode u_decode (
    .data_off  (data_off),
    .clk_off   (clk_off),
    .dir_btoa  (dir_btoa),
    .cap_local (cap_local),
    .route     (route)
  );

  assign clk_lvl[CLK_SYS] = sys_clk_i;
  assign clk_lvl[CLK_FWD] = fclk_in;

  clkfwd_xcvr_edge #(.NUM(NUM_CLK)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (clk_lvl),
    .rise  (clk_rise)
  );

  assign ab_load = route.ld_ab && clk_rise[CLK_SYS];
  assign ba_load = route.ld_ba &&
                   (route.ba_on_sys ? clk_rise[CLK_SYS] : clk_rise[CLK_FWD]);

  clkfwd_xcvr_capture #(.WIDTH(WIDTH)) u_reg_ab (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ab_load),
    .d     (a_in),
    .q     (ab_q)
  );

  clkfwd_xcvr_capture #(.WIDTH(WIDTH)) u_reg_ba (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ba_load),
    .d     (b_in),
    .q     (ba_q)
  );

  assign b_out      = route.use_reg ? ab_q : a_in;
  assign a_out      = route.use_reg ? ba_q : b_in;
  assign a_drive    = route.a_drv;
  assign b_drive    = route.b_drv;
  assign fclk_out   = sys_clk_i;
  assign fclk_drive = route.fclk_drv;
  assign lclk_out   = route.lclk_fwd ? fclk_in : sys_clk_i;
  assign lclk_drive = route.lclk_drv;

endmodule

// File: rtl/clkfwd_xcvr_chk.sv
module clkfwd_xcvr_chk #(
  parameter int WIDTH = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sys_clk_i,
  input logic             data_off,
  input logic             clk_off,
  input logic             dir_btoa,
  input logic             cap_local,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_drive,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_drive,
  input logic             fclk_in,
  input logic             fclk_out,
  input logic             fclk_drive,
  input logic             lclk_out,
  input logic             lclk_drive
);

  logic sys_seen_q;
  always_ff @(posedge clk) begin
    if (!rst_n) sys_seen_q <= 1'b0;
    else        sys_seen_q <= sys_clk_i;
  end

  assert_one_side_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_drive && b_drive));

  assert_isolate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (data_off && !clk_off) |-> (!a_drive && !b_drive && lclk_drive));

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_off && !data_off && !dir_btoa && sys_clk_i && !sys_seen_q)
    |=> (dir_btoa || clk_off || data_off || b_out == $past(a_in)));

  assert_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_off && !data_off && !dir_btoa) |-> (b_drive && b_out == a_in && !fclk_drive));

  assert_fwd_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_btoa && !clk_off && !cap_local) |-> (!fclk_drive && lclk_out == fclk_in));

  assert_all_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (data_off && clk_off) |-> !(a_drive || b_drive || fclk_drive || lclk_drive));

endmodule

bind clkfwd_xcvr clkfwd_xcvr_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/sim_clkfwd_xcvr.sv
module sim_clkfwd_xcvr;

  localparam int CLK_PERIOD = 10;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sys_clk_i = 1'b0;
  logic         data_off = 1'b0;
  logic         clk_off = 1'b0;
  logic         dir_btoa = 1'b0;
  logic         cap_local = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic         fclk_in = 1'b0;
  logic [W-1:0] a_out, b_out;
  logic         a_drive, b_drive, fclk_out, fclk_drive, lclk_out, lclk_drive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkfwd_xcvr #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .sys_clk_i(sys_clk_i), .data_off(data_off),
    .clk_off(clk_off), .dir_btoa(dir_btoa), .cap_local(cap_local),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
    .fclk_in(fclk_in), .fclk_out(fclk_out), .fclk_drive(fclk_drive),
    .lclk_out(lclk_out), .lclk_drive(lclk_drive)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_ctl(input logic doff, input logic coff,
                         input logic dir, input logic cap);
    data_off = doff; clk_off = coff; dir_btoa = dir; cap_local = cap;
    #1;
  endtask

  task automatic sys_pulse();
    sys_clk_i = 1'b1; tick();
    sys_clk_i = 1'b0; tick();
  endtask

  task automatic fwd_pulse();
    fclk_in = 1'b1; tick();
    fclk_in = 1'b0; tick();
  endtask

  task automatic t_reset();
    set_ctl(0, 0, 0, 0);
    chk("R12", "A-to-B reg after reset", b_out, 0);
    chk("R1", "b_drive in A-to-B", b_drive, 1);
    set_ctl(0, 0, 1, 1);
    chk("R12", "B-to-A reg after reset", a_out, 0);
    chk("R1", "a_drive in B-to-A", a_drive, 1);
  endtask

  task automatic t_reg_atob();
    set_ctl(0, 0, 0, 0);
    a_in = 18'h2A5A5; sys_pulse();
    chk("R3", "A-to-B capture", b_out, 18'h2A5A5);
    a_in = 18'h3FFFF; sys_pulse();
    chk("R3", "A-to-B capture all ones", b_out, 18'h3FFFF);
    chk("R1", "a_drive low in A-to-B", a_drive, 0);
  endtask

  task automatic t_hold();
    set_ctl(0, 0, 0, 0);
    a_in = 18'h00001; tick(); tick();
    chk("R4", "hold without edge", b_out, 18'h3FFFF);
    sys_clk_i = 1'b1; tick(); tick();
    a_in = 18'h15555; tick();
    chk("R4", "hold while system clock stays high", b_out, 18'h00001);
    sys_clk_i = 1'b0; tick();
  endtask

  task automatic t_clocks_atob();
    set_ctl(0, 0, 0, 0);
    sys_clk_i = 1'b1; #1;
    chk("R6", "fclk_drive", fclk_drive, 1);
    chk("R6", "fclk_out high", fclk_out, 1);
    chk("R6", "lclk_out high", lclk_out, 1);
    sys_clk_i = 1'b0; #1;
    chk("R6", "fclk_out low", fclk_out, 0);
    set_ctl(1, 0, 0, 0);
    chk("R6", "fclk_drive while data released", fclk_drive, 1);
    chk("R6", "lclk_drive while data released", lclk_drive, 1);
    tick();
  endtask

  task automatic t_transparent();
    set_ctl(0, 1, 0, 0);
    a_in = 18'h12345; #1;
    chk("R5", "A to B pass", b_out, 18'h12345);
    chk("R5", "fclk released", fclk_drive, 0);
    chk("R5", "lclk released", lclk_drive, 0);
    set_ctl(0, 1, 1, 0);
    b_in = 18'h20001; #1;
    chk("R5", "B to A pass", a_out, 18'h20001);
    b_in = 18'h0ABCD; #1;
    chk("R5", "B to A follows", a_out, 18'h0ABCD);
    tick();
  endtask

  task automatic t_src_sync();
    set_ctl(0, 0, 1, 0);
    chk("R7", "fclk not driven", fclk_drive, 0);
    fclk_in = 1'b1; #1;
    chk("R7", "lclk follows fclk", lclk_out, 1);
    fclk_in = 1'b0; tick();
    b_in = 18'h1C3C3; sys_pulse();
    chk("R7", "no capture on system edge", a_out, 0);
    fwd_pulse();
    chk("R7", "capture on forwarded edge", a_out, 18'h1C3C3);
  endtask

  task automatic t_clk_sync();
    set_ctl(0, 0, 1, 1);
    chk("R8", "fclk driven", fclk_drive, 1);
    sys_clk_i = 1'b1; #1;
    chk("R8", "fclk_out follows system clock", fclk_out, 1);
    chk("R8", "lclk follows system clock", lclk_out, 1);
    sys_clk_i = 1'b0; tick();
    b_in = 18'h2AAAA; fwd_pulse();
    chk("R8", "no capture on forwarded edge", a_out, 18'h1C3C3);
    sys_pulse();
    chk("R8", "capture on system edge", a_out, 18'h2AAAA);
  endtask

  task automatic t_retain();
    set_ctl(0, 0, 0, 0);
    a_in = 18'h0F0F0; sys_pulse();
    set_ctl(0, 0, 1, 1);
    a_in = 18'h33333; b_in = 18'h04444; sys_pulse();
    chk("R11", "B-to-A loaded", a_out, 18'h04444);
    set_ctl(0, 0, 0, 1);
    chk("R11", "A-to-B kept across direction change", b_out, 18'h0F0F0);
    b_in = 18'h3EEEE; sys_pulse();
    set_ctl(0, 0, 1, 1);
    chk("R11", "B-to-A kept across direction change", a_out, 18'h04444);
  endtask

  task automatic t_isolate();
    set_ctl(1, 0, 0, 1);
    chk("R2", "a_drive released", a_drive, 0);
    chk("R2", "b_drive released", b_drive, 0);
    chk("R2", "lclk still driven", lclk_drive, 1);
    a_in = 18'h11111; b_in = 18'h22222; sys_pulse();
    set_ctl(0, 0, 0, 1);
    chk("R9", "A stored in isolation", b_out, 18'h11111);
    set_ctl(0, 0, 1, 1);
    chk("R9", "B stored in isolation", a_out, 18'h22222);
    set_ctl(1, 0, 1, 0);
    b_in = 18'h25252; fwd_pulse();
    set_ctl(0, 0, 1, 0);
    chk("R9", "B stored on forwarded edge in isolation", a_out, 18'h25252);
  endtask

  task automatic t_all_off();
    set_ctl(1, 1, 0, 0);
    chk("R10", "drives with dir 0", {a_drive, b_drive, fclk_drive, lclk_drive}, 0);
    set_ctl(1, 1, 1, 1);
    chk("R10", "drives with dir 1", {a_drive, b_drive, fclk_drive, lclk_drive}, 0);
  endtask

  task automatic t_truth_table();
    for (int i = 0; i < 16; i++) begin
      logic doff, coff, dir, cap;
      logic [3:0] exp;
      {doff, coff, dir, cap} = i[3:0];
      set_ctl(doff, coff, dir, cap);
      exp[3] = !doff && dir;
      exp[2] = !doff && !dir;
      exp[1] = !coff && (!dir || cap);
      exp[0] = !coff;
      chk("R1", $sformatf("drive enables, control %0d", i),
          {a_drive, b_drive, fclk_drive, lclk_drive}, exp);
    end
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_reg_atob();
    t_hold();
    t_clocks_atob();
    t_transparent();
    t_src_sync();
    t_clk_sync();
    t_retain();
    t_isolate();
    t_all_off();
    t_truth_table();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule